// File: doc/BRIEF.md
# Pipelined SPI ADC Scan Sequencer

This block is an SPI master for a multichannel successive-approximation converter that answers every command two frames late. A single-cycle trigger starts a scan. The block latches a 16-bit channel-enable mask and a range-select bit, then sends one command frame for each enabled channel, lowest index first. It follows these with two padding frames so that the last replies can come back. The replies to the first two frames belong to no command of this scan and are dropped. Every later reply is paired with the channel whose command went out two frames earlier.

Each reply carries a 4-bit channel tag and a 12-bit result field. The block compares the tag against the channel it expects and reports any difference on an error flag that travels with the sample. The result is shifted right to the configured resolution, so a lower-resolution converter yields a plain integer of that width. A one-cycle done strobe closes the scan once chip select has been released after the final frame.

Top module: `spi_scan_seq`

## Requirements
- R1: Every frame is 16 SCLK periods long and is shifted MSB first in SPI mode 0. SCLK idles low. MOSI changes only when SCLK falls, and MISO is sampled when SCLK rises.
- R2: Chip select goes high after every frame. Between two frames of the same scan it stays high for at least CLK_DIV system clock cycles, which is one SCLK period.
- R3: A command frame carries bit 12 = 1 (manual channel select), bit 11 = 1 (program write), the channel number in bits 10:7 and the latched range bit in bit 6. Every other bit is 0.
- R4: A scan with N enabled channels uses exactly N+2 frames. The first N frames address the enabled channels in ascending index order, and the last two frames send all zeros.
- R5: The replies of the first two frames are discarded. Each later reply produces one single-cycle `resValid` pulse, with `resChan` set to the channel commanded two frames earlier. A scan yields exactly N results, in command order.
- R6: `resSample` equals reply bits 11:0 shifted right by 12 − RES_BITS, so that it is right-aligned.
- R7: `resMismatch` is high together with `resValid` exactly when reply bits 15:12 differ from `resChan`. It is never high without `resValid`.
- R8: `scanDone` is a one-cycle pulse. It is issued while chip select is high after the last frame, and never in the same cycle as `resValid`.
- R9: The mask and range bit are latched when a scan starts. A trigger that arrives while a scan is running is ignored. A trigger in the cycle where `scanDone` is high starts a new scan.
- R10: A trigger with an all-zero mask raises `scanDone` in the next cycle and produces no frame.
- R11: After reset, `csN` is 1, `sclk` is 0, `mosi` is 0, and `resValid` and `scanDone` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigger | input | 1 | Starts a scan when the block is idle |
| chanMask | input | 16 | Channel-enable mask; bit i enables channel i |
| rangeHigh | input | 1 | Selects the doubled input range in commands |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial command data to the converter |
| csN | output | 1 | Active-low chip select |
| resValid | output | 1 | Result strobe |
| resChan | output | 4 | Channel the result belongs to |
| resSample | output | 12 | Right-aligned conversion result |
| resMismatch | output | 1 | Reply tag differs from the expected channel |
| scanDone | output | 1 | End-of-scan pulse |

## Verification
The completion of one scan and the acceptance of the next trigger can fall in the same cycle. The bench therefore raises `trigger` with a new mask in exactly the cycle where it sees `scanDone`. It judges the handover by whether the second scan then sends the commands and frame count of the new mask. As a contrast, a trigger with a different mask pulsed in the middle of a scan must leave that scan's commands, frame count and results unchanged. The tag check is exercised alongside the result path: the converter model inverts the tag of one chosen channel, and only that channel's result may carry the error flag.

// File: rtl/spi_scan_pkg.sv
package spi_scan_pkg;
  localparam int WORD_W = 16;
  localparam int CH_W = 4;
  localparam int NUM_CH = 16;
  localparam int RAW_W = 12;
  // command word bit positions, decoded by the converter
  localparam int BIT_MANUAL = 12;
  localparam int BIT_WRITE = 11;
  localparam int BIT_CH_LO = 7;
  localparam int BIT_RANGE = 6;

  typedef struct packed {
    logic startScan;
    logic loadFrame;
    logic sampleBit;
    logic shiftBit;
    logic endFrame;
  } seqStrobeT;
endpackage

// File: rtl/spi_scan_ctrl.sv
module spi_scan_ctrl
  import spi_scan_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      trigger,
  input  logic      maskZero,
  input  logic      moreWork,
  output seqStrobeT strobe,
  output logic      sclk,
  output logic      csN,
  output logic      scanDone
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = $clog2(WORD_W);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_GAP} seqStateT;

  seqStateT state;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic tickEnd;
  logic lastBit;

  assign tickEnd = (divCnt == DIV_W'(CLK_DIV - 1));
  assign lastBit = (bitCnt == BIT_W'(WORD_W - 1));

  always_comb begin
    strobe = '0;
    strobe.startScan = (state == ST_IDLE) && trigger && !maskZero;
    strobe.loadFrame = (state == ST_LOAD);
    strobe.sampleBit = (state == ST_SHIFT) && (divCnt == DIV_W'(HALF - 1));
    strobe.shiftBit  = (state == ST_SHIFT) && tickEnd && !lastBit;
    strobe.endFrame  = (state == ST_SHIFT) && tickEnd && lastBit;
  end

  // low half of each bit period first, then high half (mode 0)
  assign sclk = (state == ST_SHIFT) && (divCnt >= DIV_W'(HALF));
  assign csN  = (state != ST_SHIFT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      bitCnt   <= '0;
      scanDone <= 1'b0;
    end else begin
      scanDone <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (trigger) begin
            if (maskZero) scanDone <= 1'b1;
            else          state    <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          state  <= ST_SHIFT;
          divCnt <= '0;
          bitCnt <= '0;
        end
        ST_SHIFT: begin
          if (tickEnd) begin
            divCnt <= '0;
            if (lastBit) state <= ST_GAP;
            else         bitCnt <= bitCnt + 1'b1;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (tickEnd) begin
            divCnt <= '0;
            if (moreWork) begin
              state <= ST_LOAD;
            end else begin
              state    <= ST_IDLE;
              scanDone <= 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_scan_datapath.sv
module spi_scan_datapath
  import spi_scan_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strobe,
  input  logic [NUM_CH-1:0] chanMask,
  input  logic              rangeHigh,
  input  logic              miso,
  output logic              mosi,
  output logic              maskZero,
  output logic              moreWork,
  output logic              resValid,
  output logic [CH_W-1:0]   resChan,
  output logic [RAW_W-1:0]  resSample,
  output logic              resMismatch
);
  localparam int ALIGN_SHIFT = RAW_W - RES_BITS;
  localparam int LAG = 2;

  logic [NUM_CH-1:0] remMask;
  logic              rangeLat;
  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;
  logic              curValid;
  logic [CH_W-1:0]   curChan;
  logic [LAG-1:0]            pipeValid;
  logic [LAG-1:0][CH_W-1:0]  pipeChan;
  logic [CH_W-1:0]   nextChan;
  logic [WORD_W-1:0] cmdWord;

  function automatic logic [CH_W-1:0] lowestSet(input logic [NUM_CH-1:0] m);
    lowestSet = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (m[i]) lowestSet = CH_W'(i);
    end
  endfunction

  assign nextChan = lowestSet(remMask);

  always_comb begin
    cmdWord = '0;
    cmdWord[BIT_MANUAL] = 1'b1;
    cmdWord[BIT_WRITE]  = 1'b1;
    cmdWord[BIT_CH_LO +: CH_W] = nextChan;
    cmdWord[BIT_RANGE]  = rangeLat;
  end

  assign mosi     = txShift[WORD_W-1];
  assign maskZero = (chanMask == '0);
  assign moreWork = (|remMask) || (|pipeValid);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remMask     <= '0;
      rangeLat    <= 1'b0;
      txShift     <= '0;
      rxShift     <= '0;
      curValid    <= 1'b0;
      curChan     <= '0;
      pipeValid   <= '0;
      pipeChan    <= '0;
      resValid    <= 1'b0;
      resChan     <= '0;
      resSample   <= '0;
      resMismatch <= 1'b0;
    end else begin
      resValid    <= 1'b0;
      resMismatch <= 1'b0;
      if (strobe.startScan) begin
        remMask   <= chanMask;
        rangeLat  <= rangeHigh;
        pipeValid <= '0;
      end
      if (strobe.loadFrame) begin
        if (|remMask) begin
          curValid          <= 1'b1;
          curChan           <= nextChan;
          remMask[nextChan] <= 1'b0;
          txShift           <= cmdWord;
        end else begin
          curValid <= 1'b0;
          txShift  <= '0;
        end
      end
      if (strobe.sampleBit) rxShift <= {rxShift[WORD_W-2:0], miso};
      if (strobe.shiftBit)  txShift <= {txShift[WORD_W-2:0], 1'b0};
      if (strobe.endFrame) begin
        txShift      <= '0;
        pipeValid[1] <= pipeValid[0];
        pipeChan[1]  <= pipeChan[0];
        pipeValid[0] <= curValid;
        pipeChan[0]  <= curChan;
        resValid     <= pipeValid[1];
        resChan      <= pipeChan[1];
        resSample    <= rxShift[RAW_W-1:0] >> ALIGN_SHIFT;
        resMismatch  <= pipeValid[1] && (rxShift[WORD_W-1 -: CH_W] != pipeChan[1]);
      end
    end
  end
endmodule

// File: rtl/spi_scan_seq.sv
module spi_scan_seq
  import spi_scan_pkg::*;
#(
  parameter int CLK_DIV  = 4,
  parameter int RES_BITS = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigger,
  input  logic [15:0] chanMask,
  input  logic        rangeHigh,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        csN,
  output logic        resValid,
  output logic [3:0]  resChan,
  output logic [11:0] resSample,
  output logic        resMismatch,
  output logic        scanDone
);
  seqStrobeT strobe;
  logic maskZero;
  logic moreWork;

  spi_scan_ctrl #(.CLK_DIV(CLK_DIV)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .trigger  (trigger),
    .maskZero (maskZero),
    .moreWork (moreWork),
    .strobe   (strobe),
    .sclk     (sclk),
    .csN      (csN),
    .scanDone (scanDone)
  );

  spi_scan_datapath #(.RES_BITS(RES_BITS)) data_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .chanMask    (chanMask),
    .rangeHigh   (rangeHigh),
    .miso        (miso),
    .mosi        (mosi),
    .maskZero    (maskZero),
    .moreWork    (moreWork),
    .resValid    (resValid),
    .resChan     (resChan),
    .resSample   (resSample),
    .resMismatch (resMismatch)
  );
endmodule

// File: rtl/spi_scan_seq_chk.sv
module spi_scan_seq_chk #(
  parameter int CLK_DIV = 4,
  parameter int WORD_W  = 16
) (
  input logic clk,
  input logic rstN,
  input logic sclk,
  input logic mosi,
  input logic csN,
  input logic resValid,
  input logic resMismatch,
  input logic scanDone
);
  logic [31:0] highCnt;
  logic [31:0] edgeCnt;
  logic        sclkQ;
  logic        inScan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCnt <= '0;
      edgeCnt <= '0;
      sclkQ   <= 1'b0;
      inScan  <= 1'b0;
    end else begin
      sclkQ <= sclk;
      if (csN) begin
        edgeCnt <= '0;
        if (highCnt < 32'(CLK_DIV)) highCnt <= highCnt + 1;
      end else begin
        highCnt <= '0;
        if (sclk && !sclkQ) edgeCnt <= edgeCnt + 1;
      end
      if (scanDone)  inScan <= 1'b0;
      else if (!csN) inScan <= 1'b1;
    end
  end

  // R1: serial clock parked low whenever chip select is released
  assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R1: MOSI held while SCLK stays high
  assert_mosi_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R1: sixteen rising SCLK edges per frame
  assert_frame_len_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (edgeCnt == 32'(WORD_W)));

  // R2: inter-frame gap of at least one SCLK period
  assert_cs_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(csN) && inScan) |-> (highCnt >= 32'(CLK_DIV)));

  // R5: result strobe lasts one cycle
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  // R7: error flag only travels with a result
  assert_mismatch_qual_R7: assert property (@(posedge clk) disable iff (!rstN)
    resMismatch |-> resValid);

  // R8: done is a pulse, with chip select high and no result
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> !scanDone);
  assert_done_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |-> (csN && !resValid));
endmodule

bind spi_scan_seq spi_scan_seq_chk #(.CLK_DIV(CLK_DIV), .WORD_W(16)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .sclk        (sclk),
  .mosi        (mosi),
  .csN         (csN),
  .resValid    (resValid),
  .resMismatch (resMismatch),
  .scanDone    (scanDone)
);

// File: tb/spi_scan_seq_tb_top.sv
`timescale 1ns/1ps
module spi_scan_seq_tb_top;
  localparam int CLK_DIV = 4;
  localparam realtime CLK_NS = 5.0;

  // {mask[15:0], range, corrupt, corruptChan[3:0], seed[11:0]}
  localparam logic [33:0] VEC_TABLE [6] = '{
    {16'h0001, 1'b0, 1'b0, 4'h0, 12'h111},
    {16'h8000, 1'b1, 1'b0, 4'h0, 12'h262},
    {16'h00A5, 1'b1, 1'b1, 4'h5, 12'h3B3},
    {16'hFFFF, 1'b0, 1'b1, 4'h0, 12'h404},
    {16'h1234, 1'b0, 1'b0, 4'h0, 12'h5C5},
    {16'h0180, 1'b1, 1'b1, 4'h8, 12'h6E6}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, trigger, rangeHigh, miso;
  logic [15:0] chanMask;
  logic sclk, mosi, csN, resValid, resMismatch, scanDone;
  logic [3:0] resChan;
  logic [11:0] resSample;
  logic sclk8, mosi8, csN8, res8Valid, res8Mismatch, scan8Done;
  logic [3:0] res8Chan;
  logic [11:0] res8Sample;

  spi_scan_seq #(.CLK_DIV(CLK_DIV), .RES_BITS(12)) dut_i (
    .clk(clk), .rstN(rstN), .trigger(trigger), .chanMask(chanMask), .rangeHigh(rangeHigh),
    .miso(miso), .sclk(sclk), .mosi(mosi), .csN(csN), .resValid(resValid), .resChan(resChan),
    .resSample(resSample), .resMismatch(resMismatch), .scanDone(scanDone));

  spi_scan_seq #(.CLK_DIV(CLK_DIV), .RES_BITS(8)) dut8_i (
    .clk(clk), .rstN(rstN), .trigger(trigger), .chanMask(chanMask), .rangeHigh(rangeHigh),
    .miso(miso), .sclk(sclk8), .mosi(mosi8), .csN(csN8), .resValid(res8Valid), .resChan(res8Chan),
    .resSample(res8Sample), .resMismatch(res8Mismatch), .scanDone(scan8Done));

  int testCnt = 0;
  int failCnt = 0;
  logic benchDone = 1'b0;

  logic [15:0] txWord, rxCmd;
  logic [3:0]  tagQ;
  int bitIdx, frameCnt, expFrames, expN, resIdx, res8Idx;
  logic inFrame;
  logic [15:0] expCmd [18];
  logic [3:0]  expChan [16];
  logic [3:0]  histChan [2];
  logic        histValid [2];
  logic        corruptOn;
  logic [3:0]  corruptChan;
  logic [11:0] seed;
  realtime     lastRise;

  task automatic check(input logic ok, input string req, input string what, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] dataFor(input logic [3:0] ch);
    return 12'(ch * 12'h0B7) + seed;
  endfunction

  function automatic logic [15:0] cmdFor(input logic [3:0] ch, input logic rng);
    return 16'h1800 | (16'(ch) << 7) | (16'(rng) << 6);
  endfunction

  // converter model: reply to the command two frames back
  always @(negedge csN) begin
    if (frameCnt > 0)
      check(($realtime - lastRise) >= CLK_DIV * CLK_NS, "R2", "cs gap ns",
            int'($realtime - lastRise), CLK_DIV * 5);
    if (histValid[1]) begin
      tagQ = histChan[1];
      if (corruptOn && histChan[1] == corruptChan) tagQ = ~tagQ;
      txWord = {tagQ, dataFor(histChan[1])};
    end else begin
      txWord = 16'hFFFF;
    end
    miso = txWord[15];
    bitIdx = 0;
    rxCmd = '0;
    inFrame = 1'b1;
  end

  always @(posedge sclk) if (!csN) begin
    rxCmd = {rxCmd[14:0], mosi};
    bitIdx++;
  end

  always @(negedge sclk) if (!csN) begin
    txWord = {txWord[14:0], 1'b0};
    miso = txWord[15];
  end

  always @(posedge csN) if (rstN && inFrame) begin
    inFrame = 1'b0;
    lastRise = $realtime;
    check(bitIdx == 16, "R1", "bits per frame", bitIdx, 16);
    if (frameCnt < expFrames) begin
      if (frameCnt < expN) check(rxCmd == expCmd[frameCnt], "R3", "command word", rxCmd, expCmd[frameCnt]);
      else                 check(rxCmd == 16'h0, "R4", "padding frame", rxCmd, 0);
    end else begin
      check(1'b0, "R4", "extra frame", frameCnt, expFrames);
    end
    histValid[1] = histValid[0];
    histChan[1]  = histChan[0];
    histValid[0] = rxCmd[12] & rxCmd[11];
    histChan[0]  = rxCmd[10:7];
    frameCnt++;
  end

  // result monitors, sampled mid-cycle
  always @(negedge clk) if (rstN) begin
    if (resValid) begin
      if (resIdx < expN) begin
        check(resChan == expChan[resIdx], "R5", "result channel", resChan, expChan[resIdx]);
        check(resSample == dataFor(expChan[resIdx]), "R6", "12-bit sample", resSample, dataFor(expChan[resIdx]));
        check(resMismatch == (corruptOn && expChan[resIdx] == corruptChan), "R7", "tag mismatch",
              resMismatch, corruptOn && expChan[resIdx] == corruptChan);
      end else begin
        check(1'b0, "R5", "extra result", resIdx, expN);
      end
      resIdx++;
    end
    if (res8Valid) begin
      if (res8Idx < expN)
        check(res8Sample == (dataFor(expChan[res8Idx]) >> 4), "R6", "8-bit sample",
              res8Sample, dataFor(expChan[res8Idx]) >> 4);
      res8Idx++;
    end
  end

  task automatic startScan(input logic [15:0] m, input logic r, input logic cOn,
                           input logic [3:0] cCh, input logic [11:0] sd);
    expN = 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        expChan[expN] = 4'(i);
        expCmd[expN]  = cmdFor(4'(i), r);
        expN++;
      end
    end
    expFrames = expN + 2;
    frameCnt = 0; resIdx = 0; res8Idx = 0;
    histValid[0] = 1'b0; histValid[1] = 1'b0;
    corruptOn = cOn; corruptChan = cCh; seed = sd;
    chanMask = m; rangeHigh = r; trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
  endtask

  task automatic finishScan();
    int waitCnt = 0;
    while (!scanDone && waitCnt < 20000) begin
      @(negedge clk);
      waitCnt++;
    end
    check(scanDone == 1'b1, "R8", "done pulse seen", scanDone, 1);
    check(frameCnt == expFrames, "R4", "frames per scan", frameCnt, expFrames);
    check(resIdx == expN, "R5", "results per scan", resIdx, expN);
    check(res8Idx == expN, "R6", "8-bit results per scan", res8Idx, expN);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!benchDone) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; trigger = 1'b0; chanMask = '0; rangeHigh = 1'b0; miso = 1'b0;
    frameCnt = 0; expFrames = 0; expN = 0; resIdx = 0; res8Idx = 0; bitIdx = 0;
    inFrame = 1'b0; histValid[0] = 1'b0; histValid[1] = 1'b0;
    histChan[0] = '0; histChan[1] = '0; corruptOn = 1'b0; corruptChan = '0; seed = '0;
    lastRise = 0.0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    check(csN == 1'b1, "R11", "csN after reset", csN, 1);
    check(sclk == 1'b0, "R11", "sclk after reset", sclk, 0);
    check(mosi == 1'b0, "R11", "mosi after reset", mosi, 0);
    check(resValid == 1'b0, "R11", "resValid after reset", resValid, 0);
    check(scanDone == 1'b0, "R11", "scanDone after reset", scanDone, 0);

    // table of scans
    for (int v = 0; v < 6; v++) begin
      startScan(VEC_TABLE[v][33:18], VEC_TABLE[v][17], VEC_TABLE[v][16],
                VEC_TABLE[v][15:12], VEC_TABLE[v][11:0]);
      finishScan();
      repeat (3) @(negedge clk);
    end

    // R10 all-zero mask
    expN = 0; expFrames = 0; frameCnt = 0; resIdx = 0; res8Idx = 0;
    chanMask = 16'h0000; trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    check(scanDone == 1'b1, "R10", "done for empty mask", scanDone, 1);
    @(negedge clk);
    check(scanDone == 1'b0, "R8", "done lasts one cycle", scanDone, 0);
    repeat (20) @(negedge clk);
    check(frameCnt == 0, "R10", "frames for empty mask", frameCnt, 0);

    // R9 trigger in mid-scan ignored, mask latched
    startScan(16'h0003, 1'b0, 1'b0, 4'h0, 12'h0F0);
    repeat (100) @(negedge clk);
    chanMask = 16'hFFFF; rangeHigh = 1'b1; trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    finishScan();
    repeat (60) @(negedge clk);
    check(frameCnt == 4, "R9", "mid-scan trigger ignored", frameCnt, 4);

    // R9 trigger in the done cycle starts the next scan
    startScan(16'h0003, 1'b1, 1'b0, 4'h0, 12'h0A0);
    finishScan();
    startScan(16'h0C00, 1'b0, 1'b1, 4'hB, 12'h0C0);
    finishScan();
    check(frameCnt == 4, "R9", "back-to-back scan frames", frameCnt, 4);

    benchDone = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule